// File: doc/BRIEF.md
# Buffered Page Program Sequencer

This block writes a byte stream of arbitrary length, starting at an arbitrary byte offset, into a paged serial flash that programs through an on-chip page buffer. It divides the start offset by the run-time page size. It then walks the request page by page. For each page it issues the device commands through an abstract command engine and returns one done pulse, with an error flag when the write failed.

A page that is written only in part is first copied from the array into the device buffer, so that the bytes outside the written range are kept. Every page is then written with a program-through-buffer command whose payload is taken from the input stream. When verification is on, each page is compared against the buffer afterwards. A mismatch stops the whole request with an error. After every command the block polls the device status until the ready bit is set.

The input stream is valid/ready. Bytes are taken only while a program command's payload is in flight, and they are passed straight through to the engine's payload channel. So `in_ready` follows `pay_ready`, and either side may stall at any beat without losing or repeating a byte. Control inputs are sampled on the accepted `start` pulse. The command channel holds its request stable until `cmd_ready`.

Top module: `pgseq_top`

## Requirements
- R1: While reset is asserted, and after it, `busy`, `done`, `error`, `cmd_valid`, `pay_valid` and `in_ready` are low.
- R2: The first chunk has length min(page_size - offset mod page_size, length). Every later chunk has length min(page_size, bytes remaining). Each chunk is written with op 0x82 at address (page_number << page_shift) + in-page offset, with `cmd_len` equal to the chunk length. The in-page offset is zero after the first chunk.
- R3: A chunk shorter than page_size is preceded by a buffer-load command, op 0x53, at the page address with address bits [7:0] forced to zero and `cmd_len` 0. A full-page chunk has no load.
- R4: After each command other than a status read completes, the block issues status reads (op 0xD7, address 0, `cmd_len` 0) until the returned byte has bit 7 set. No other command is issued before that.
- R5: With `verify_en` set at start, each program is followed by a compare command, op 0x60, at the page address with bits [7:0] zero and `cmd_len` 0.
- R6: If the ready status after a compare has bit 6 set, the block ends with `done` and `error` high and issues no further command.
- R7: Input bytes reach `pay_data` in order. `in_ready` is high only during a program payload, and for no more than `cmd_len` beats. A stall on either side of the stream neither drops nor repeats a byte.
- R8: `done` is a one-cycle pulse, and `busy` is low in the cycle after it. `error` is high only together with `done`, and it stays low for a request that completes.
- R9: A length of 0 ends with `done` and no error. A page size of 0 ends with `done` and `error`. In both cases no command is issued.
- R10: A `start` pulse while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch a request (used only when idle) |
| start_offset | input | ADDR_W | Start byte offset in the flash |
| start_len | input | LEN_W | Number of bytes to write |
| page_size | input | PS_W | Bytes per page |
| page_shift | input | SH_W | Left shift turning page number into page address |
| verify_en | input | 1 | Run a compare after each page |
| in_valid | input | 1 | Input stream byte valid |
| in_ready | output | 1 | Input stream byte taken |
| in_data | input | 8 | Input stream byte |
| cmd_valid | output | 1 | Command request |
| cmd_ready | input | 1 | Engine accepts the command |
| cmd_op | output | 8 | Opcode |
| cmd_addr | output | ADDR_W | Three-byte address field |
| cmd_len | output | LEN_W | Payload byte count |
| cmd_done | input | 1 | Engine finished the command |
| cmd_rdata | input | 8 | Byte returned by a status read, valid with `cmd_done` |
| pay_valid | output | 1 | Payload byte valid |
| pay_ready | input | 1 | Engine takes the payload byte |
| pay_data | output | 8 | Payload byte |
| busy | output | 1 | Request in progress |
| done | output | 1 | Request finished (pulse) |
| error | output | 1 | Request failed (with `done`) |

## Verification
The hardest case to reach from the ports is a compare mismatch on a middle page of a request whose first page is partial. The mismatch has to come after several busy polls, and it must cut the command stream at once. The bench's device model returns busy on the first poll after every command. It raises the mismatch bit only on the ready status that follows the compare of a chosen page. Vectors pick that page, and they also turn on back-pressure on both the input stream and the payload channel. A second `start` with different values is pulsed in the middle of each run to show that it has no effect on the command log.

// File: rtl/pgseq_pkg.sv
package pgseq_pkg;
  localparam logic [7:0] OP_LOAD   = 8'h53;
  localparam logic [7:0] OP_PROG   = 8'h82;
  localparam logic [7:0] OP_CMP    = 8'h60;
  localparam logic [7:0] OP_STATUS = 8'hD7;
  localparam int         RDY_BIT   = 7;
  localparam int         MISM_BIT  = 6;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DIV, ST_PLAN, ST_ISSUE, ST_FLOW, ST_POLL_ISSUE, ST_POLL_WAIT, ST_FINISH
  } state_t;
endpackage

// File: rtl/pgseq_div.sv
module pgseq_div #(
  parameter int ADDR_W = 24,
  parameter int PS_W   = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [ADDR_W-1:0] dividend,
  input  logic [PS_W-1:0]   divisor,
  output logic              fin,
  output logic [ADDR_W-1:0] quot,
  output logic [PS_W-1:0]   rem
);
  localparam int CNT_W = $clog2(ADDR_W + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [ADDR_W-1:0] q_q;
  logic [PS_W-1:0]   r_q;
  logic [PS_W-1:0]   dv_q;
  logic              fin_q;
  logic [PS_W:0]     trial;
  logic              take;

  assign trial = {r_q, q_q[ADDR_W-1]};
  assign take  = trial >= {1'b0, dv_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      q_q   <= '0;
      r_q   <= '0;
      dv_q  <= '0;
      fin_q <= 1'b0;
    end else begin
      fin_q <= 1'b0;
      if (go) begin
        cnt_q <= CNT_W'(ADDR_W);
        q_q   <= dividend;
        r_q   <= '0;
        dv_q  <= divisor;
      end else if (cnt_q != '0) begin
        cnt_q <= cnt_q - 1'b1;
        q_q   <= {q_q[ADDR_W-2:0], take};
        r_q   <= take ? PS_W'(trial - {1'b0, dv_q}) : trial[PS_W-1:0];
        if (cnt_q == CNT_W'(1)) fin_q <= 1'b1;
      end
    end
  end

  assign fin  = fin_q;
  assign quot = q_q;
  assign rem  = r_q;
endmodule

// File: rtl/pgseq_chunk.sv
module pgseq_chunk #(
  parameter int ADDR_W = 24,
  parameter int LEN_W  = 16,
  parameter int PS_W   = 12,
  parameter int SH_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_page,
  input  logic [PS_W-1:0]   load_off,
  input  logic [LEN_W-1:0]  load_len,
  input  logic              advance,
  input  logic [PS_W-1:0]   page_size,
  input  logic [SH_W-1:0]   shift,
  output logic [LEN_W-1:0]  chunk_len,
  output logic              partial,
  output logic              last,
  output logic [ADDR_W-1:0] prog_addr,
  output logic [ADDR_W-1:0] base_addr
);
  localparam int CW = (LEN_W > PS_W) ? LEN_W : PS_W;

  logic [ADDR_W-1:0] page_q;
  logic [PS_W-1:0]   off_q;
  logic [LEN_W-1:0]  rem_q;
  logic [PS_W-1:0]   room;
  logic [CW-1:0]     room_w, rem_w, chunk_w;
  logic [ADDR_W-1:0] page_addr;

  assign room      = page_size - off_q;
  assign room_w    = CW'(room);
  assign rem_w     = CW'(rem_q);
  assign chunk_w   = (room_w < rem_w) ? room_w : rem_w;
  assign chunk_len = LEN_W'(chunk_w);
  assign partial   = chunk_w != CW'(page_size);
  assign last      = chunk_w == rem_w;
  assign page_addr = page_q << shift;
  assign prog_addr = page_addr + ADDR_W'(off_q);
  assign base_addr = {page_addr[ADDR_W-1:8], 8'h00};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      page_q <= '0;
      off_q  <= '0;
      rem_q  <= '0;
    end else if (load) begin
      page_q <= load_page;
      off_q  <= load_off;
      rem_q  <= load_len;
    end else if (advance) begin
      page_q <= page_q + 1'b1;
      off_q  <= '0;
      rem_q  <= rem_q - chunk_len;
    end
  end
endmodule

// File: rtl/pgseq_payload.sv
module pgseq_payload #(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm,
  input  logic [LEN_W-1:0] arm_len,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [7:0]       in_data,
  output logic             pay_valid,
  input  logic             pay_ready,
  output logic [7:0]       pay_data,
  output logic             active
);
  logic [LEN_W-1:0] left_q;

  assign active    = left_q != '0;
  assign pay_valid = active & in_valid;
  assign in_ready  = active & pay_ready;
  assign pay_data  = in_data;

  always_ff @(posedge clk) begin
    if (!rst_n)                       left_q <= '0;
    else if (arm)                     left_q <= arm_len;
    else if (pay_valid && pay_ready)  left_q <= left_q - 1'b1;
  end
endmodule

// File: rtl/pgseq_top.sv
module pgseq_top import pgseq_pkg::*; #(
  parameter int ADDR_W = 24,
  parameter int LEN_W  = 16,
  parameter int PS_W   = 12,
  parameter int SH_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_offset,
  input  logic [LEN_W-1:0]  start_len,
  input  logic [PS_W-1:0]   page_size,
  input  logic [SH_W-1:0]   page_shift,
  input  logic              verify_en,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_data,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [7:0]        cmd_op,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [LEN_W-1:0]  cmd_len,
  input  logic              cmd_done,
  input  logic [7:0]        cmd_rdata,
  output logic              pay_valid,
  input  logic              pay_ready,
  output logic [7:0]        pay_data,
  output logic              busy,
  output logic              done,
  output logic              error
);
  state_t            state;
  logic [7:0]        cur_op;
  logic [PS_W-1:0]   ps_q;
  logic [SH_W-1:0]   sh_q;
  logic [LEN_W-1:0]  len_q;
  logic              ver_q, err_q;

  logic              div_go, div_fin;
  logic [ADDR_W-1:0] div_quot;
  logic [PS_W-1:0]   div_rem;
  logic              ck_adv, ck_partial, ck_last;
  logic [LEN_W-1:0]  ck_len;
  logic [ADDR_W-1:0] ck_prog_addr, ck_base_addr;
  logic              pl_arm, pl_active;
  logic              poll_ok;

  assign div_go  = (state == ST_IDLE) && start && (page_size != '0) && (start_len != '0);
  assign poll_ok = (state == ST_POLL_WAIT) && cmd_done && cmd_rdata[RDY_BIT];
  assign ck_adv  = poll_ok && (((cur_op == OP_PROG) && !ver_q) ||
                               ((cur_op == OP_CMP) && !cmd_rdata[MISM_BIT]));
  assign pl_arm  = (state == ST_ISSUE) && cmd_ready && (cur_op == OP_PROG);

  pgseq_div #(.ADDR_W(ADDR_W), .PS_W(PS_W)) u_div (
    .clk(clk), .rst_n(rst_n), .go(div_go), .dividend(start_offset), .divisor(page_size),
    .fin(div_fin), .quot(div_quot), .rem(div_rem)
  );

  pgseq_chunk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .PS_W(PS_W), .SH_W(SH_W)) u_chunk (
    .clk(clk), .rst_n(rst_n), .load(div_fin), .load_page(div_quot), .load_off(div_rem),
    .load_len(len_q), .advance(ck_adv), .page_size(ps_q), .shift(sh_q),
    .chunk_len(ck_len), .partial(ck_partial), .last(ck_last),
    .prog_addr(ck_prog_addr), .base_addr(ck_base_addr)
  );

  pgseq_payload #(.LEN_W(LEN_W)) u_pay (
    .clk(clk), .rst_n(rst_n), .arm(pl_arm), .arm_len(ck_len),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .pay_valid(pay_valid), .pay_ready(pay_ready), .pay_data(pay_data), .active(pl_active)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      cur_op <= OP_PROG;
      ps_q   <= '0;
      sh_q   <= '0;
      len_q  <= '0;
      ver_q  <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (start) begin
          ps_q  <= page_size;
          sh_q  <= page_shift;
          len_q <= start_len;
          ver_q <= verify_en;
          err_q <= (page_size == '0);
          if (page_size == '0 || start_len == '0) state <= ST_FINISH;
          else                                    state <= ST_DIV;
        end
        ST_DIV:  if (div_fin) state <= ST_PLAN;
        ST_PLAN: begin
          cur_op <= ck_partial ? OP_LOAD : OP_PROG;
          state  <= ST_ISSUE;
        end
        ST_ISSUE:      if (cmd_ready) state <= ST_FLOW;
        ST_FLOW:       if (cmd_done && !pl_active) state <= ST_POLL_ISSUE;
        ST_POLL_ISSUE: if (cmd_ready) state <= ST_POLL_WAIT;
        ST_POLL_WAIT: if (cmd_done) begin
          if (!cmd_rdata[RDY_BIT]) begin
            state <= ST_POLL_ISSUE;
          end else if (cur_op == OP_LOAD) begin
            cur_op <= OP_PROG;
            state  <= ST_ISSUE;
          end else if (cur_op == OP_PROG && ver_q) begin
            cur_op <= OP_CMP;
            state  <= ST_ISSUE;
          end else if (cur_op == OP_CMP && cmd_rdata[MISM_BIT]) begin
            err_q <= 1'b1;
            state <= ST_FINISH;
          end else begin
            state <= ck_last ? ST_FINISH : ST_PLAN;
          end
        end
        ST_FINISH: state <= ST_IDLE;
        default:   state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    cmd_valid = (state == ST_ISSUE) || (state == ST_POLL_ISSUE);
    if (state == ST_POLL_ISSUE) begin
      cmd_op   = OP_STATUS;
      cmd_addr = '0;
      cmd_len  = '0;
    end else begin
      cmd_op   = cur_op;
      cmd_addr = (cur_op == OP_PROG) ? ck_prog_addr : ck_base_addr;
      cmd_len  = (cur_op == OP_PROG) ? ck_len : '0;
    end
  end

  assign busy  = state != ST_IDLE;
  assign done  = state == ST_FINISH;
  assign error = done & err_q;
endmodule

// File: rtl/pgseq_chk.sv
module pgseq_chk #(
  parameter int ADDR_W = 24,
  parameter int LEN_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              error,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [7:0]        cmd_op,
  input logic [ADDR_W-1:0] cmd_addr,
  input logic [LEN_W-1:0]  cmd_len,
  input logic              in_ready
);
  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_op) && $stable(cmd_addr) && $stable(cmd_len)); // R2
  AST_PROG_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op == 8'h82 |-> cmd_len != '0); // R2
  AST_LOAD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op == 8'h53 |-> cmd_addr[7:0] == 8'h00 && cmd_len == '0); // R3
  AST_CMP_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op == 8'h60 |-> cmd_addr[7:0] == 8'h00 && cmd_len == '0); // R5
  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> done); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !cmd_valid && !in_ready); // R7
endmodule

bind pgseq_top pgseq_chk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .error(error),
  .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
  .cmd_len(cmd_len), .in_ready(in_ready)
);

// File: tb/tb_pgseq_top.sv
module tb_pgseq_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [23:0] start_offset = '0;
  logic [15:0] start_len = '0;
  logic [11:0] page_size = '0;
  logic [3:0]  page_shift = '0;
  logic        verify_en = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_data = '0;
  logic        cmd_valid;
  logic        cmd_ready = 1'b0;
  logic [7:0]  cmd_op;
  logic [23:0] cmd_addr;
  logic [15:0] cmd_len;
  logic        cmd_done = 1'b0;
  logic [7:0]  cmd_rdata = '0;
  logic        pay_valid;
  logic        pay_ready = 1'b0;
  logic [7:0]  pay_data;
  logic        busy, done, error;

  always #10 clk = ~clk;

  pgseq_top dut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_offset(start_offset), .start_len(start_len),
    .page_size(page_size), .page_shift(page_shift), .verify_en(verify_en),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
    .cmd_len(cmd_len), .cmd_done(cmd_done), .cmd_rdata(cmd_rdata),
    .pay_valid(pay_valid), .pay_ready(pay_ready), .pay_data(pay_data),
    .busy(busy), .done(done), .error(error)
  );

  int n_checks = 0;
  int n_fail = 0;

  task automatic check(input bit ok, input string what, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  // ---------------- device model ----------------
  int eng_st = 0, eng_delay = 0, pay_left = 0, polls_since = 0, cmp_idx = 0;
  int rx_idx = 0, src_idx = 0, stray = 0, data_err = 0, nstat = 0, nlog = 0, cyc = 0;
  int mm_chunk = 99;
  bit stall = 1'b0;
  logic [7:0]  eng_op = '0, last_ns = '0;
  logic [7:0]  log_op   [64];
  logic [23:0] log_addr [64];
  logic [15:0] log_len  [64];

  initial begin
    forever begin
      @(negedge clk); #9;
      if (in_valid && in_ready) begin
        src_idx++;
        if (eng_st != 1) stray++;
      end
      if (pay_valid && pay_ready) begin
        if (pay_data != (8'(rx_idx) ^ 8'hA5)) data_err++;
        rx_idx++;
        pay_left--;
        if (pay_left <= 0) begin eng_st = 2; eng_delay = 2; end
      end
      if (cmd_valid && cmd_ready) begin
        eng_op = cmd_op;
        if (cmd_op == 8'hD7) begin
          nstat++; eng_st = 2; eng_delay = 1;
        end else begin
          if (nlog < 64) begin
            log_op[nlog] = cmd_op; log_addr[nlog] = cmd_addr; log_len[nlog] = cmd_len;
          end
          nlog++;
          last_ns = cmd_op;
          polls_since = 0;
          if (cmd_op == 8'h60) cmp_idx++;
          if (cmd_op == 8'h82 && cmd_len != 0) begin eng_st = 1; pay_left = cmd_len; end
          else begin eng_st = 2; eng_delay = 2; end
        end
      end
      @(posedge clk); #1;
      cyc++;
      cmd_done = 1'b0;
      if (eng_st == 2) begin
        if (eng_delay == 0) begin
          cmd_done = 1'b1;
          eng_st = 0;
          if (eng_op == 8'hD7) begin
            if (polls_since == 0) cmd_rdata = 8'h00;
            else cmd_rdata = 8'h80 | ((last_ns == 8'h60 && cmp_idx - 1 == mm_chunk) ? 8'h40 : 8'h00);
            polls_since++;
          end else cmd_rdata = 8'h00;
        end else eng_delay--;
      end
      cmd_ready = (eng_st == 0) && !cmd_done;
      pay_ready = (eng_st == 1) && (!stall || cyc[0]);
      in_valid  = !stall || (cyc % 3 != 2);
      in_data   = 8'(src_idx) ^ 8'hA5;
    end
  end

  // ---------------- expected command list ----------------
  int          exp_n, exp_bytes;
  bit          exp_err;
  logic [7:0]  exp_op   [64];
  logic [23:0] exp_addr [64];
  logic [15:0] exp_len  [64];

  task automatic add_exp(input logic [7:0] op, input int addr, input int len);
    exp_op[exp_n] = op; exp_addr[exp_n] = 24'(addr); exp_len[exp_n] = 16'(len);
    exp_n++;
  endtask

  task automatic build_exp(input int off, input int len, input int ps, input int sh,
                           input bit ver, input int mm);
    int pg, to, rem, cl, pa, ch;
    exp_n = 0; exp_bytes = 0; exp_err = 0;
    pg = off / ps; to = off % ps; rem = len; ch = 0;
    while (rem > 0) begin
      cl = (ps - to < rem) ? ps - to : rem;
      pa = (pg << sh) & 32'hFFFFFF;
      if (cl != ps) add_exp(8'h53, pa & 32'hFFFF00, 0);
      add_exp(8'h82, (pa + to) & 32'hFFFFFF, cl);
      exp_bytes += cl;
      if (ver) begin
        add_exp(8'h60, pa & 32'hFFFF00, 0);
        if (ch == mm) begin exp_err = 1; break; end
      end
      rem -= cl; pg++; to = 0; ch++;
    end
  endtask

  // ---------------- run one request ----------------
  bit got_done, got_err, done_after, busy_after;

  task automatic run_op(input int off, input int len, input int ps, input int sh,
                        input bit ver, input int mm, input bit stl);
    @(posedge clk); #1;
    nlog = 0; nstat = 0; rx_idx = 0; src_idx = 0; stray = 0; data_err = 0;
    cmp_idx = 0; polls_since = 0; mm_chunk = mm; stall = stl;
    start_offset = 24'(off); start_len = 16'(len); page_size = 12'(ps);
    page_shift = 4'(sh); verify_en = ver; start = 1'b1;
    got_done = 0; got_err = 0;
    for (int k = 0; k < 20000; k++) begin
      @(posedge clk); #1;
      start = (k == 20) && busy;
      if (start) begin
        start_offset = 24'd7; start_len = 16'd3; page_size = 12'd256;
        page_shift = 4'd8; verify_en = ~ver;
      end
      @(negedge clk);
      if (done) begin got_done = 1; got_err = error; break; end
    end
    @(posedge clk); #1; start = 1'b0;
    @(negedge clk);
    done_after = done; busy_after = busy;
  endtask

  typedef struct packed {
    logic [23:0] off;
    logic [15:0] len;
    logic [11:0] ps;
    logic [3:0]  sh;
    logic        ver;
    logic [3:0]  mm;
    logic        stl;
  } vec_t;

  localparam logic [61:0] VECS [0:6] = '{
    {24'd0,    16'd256, 12'd256, 4'd8,  1'b0, 4'd15, 1'b0},
    {24'd100,  16'd50,  12'd256, 4'd8,  1'b0, 4'd15, 1'b1},
    {24'd200,  16'd400, 12'd264, 4'd9,  1'b1, 4'd15, 1'b1},
    {24'd1000, 16'd600, 12'd256, 4'd8,  1'b1, 4'd1,  1'b0},
    {24'd1584, 16'd528, 12'd528, 4'd10, 1'b0, 4'd15, 1'b1},
    {24'd5,    16'd1,   12'd264, 4'd9,  1'b1, 4'd15, 1'b0},
    {24'd300,  16'd100, 12'd256, 4'd8,  1'b1, 4'd0,  1'b1}
  };

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(!busy && !done && !error, "R1 status low in reset", {busy, done, error}, 0);
    check(!cmd_valid && !pay_valid && !in_ready, "R1 channels idle in reset",
          {cmd_valid, pay_valid, in_ready}, 0);
    @(posedge clk); #1; rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !cmd_valid && !in_ready, "R1 idle after reset", {busy, cmd_valid, in_ready}, 0);

    for (int i = 0; i < 7; i++) begin
      vec_t v;
      int mis_load, mis_prog, mis_cmp;
      v = vec_t'(VECS[i]);
      build_exp(int'(v.off), int'(v.len), int'(v.ps), int'(v.sh), v.ver, int'(v.mm));
      run_op(int'(v.off), int'(v.len), int'(v.ps), int'(v.sh), v.ver, int'(v.mm), v.stl);
      mis_load = 0; mis_prog = 0; mis_cmp = 0;
      for (int j = 0; j < exp_n && j < nlog && j < 64; j++) begin
        if (log_op[j] != exp_op[j] || log_addr[j] != exp_addr[j] || log_len[j] != exp_len[j]) begin
          if (exp_op[j] == 8'h53) mis_load++;
          else if (exp_op[j] == 8'h82) mis_prog++;
          else mis_cmp++;
        end
      end
      check(got_done, $sformatf("R8 vec %0d done seen", i), got_done, 1);
      check(nlog == exp_n, $sformatf("R2 vec %0d command count", i), nlog, exp_n);
      check(nlog == exp_n, $sformatf("R10 vec %0d late start ignored", i), nlog, exp_n);
      check(mis_prog == 0, $sformatf("R2 vec %0d program commands", i), mis_prog, 0);
      check(mis_load == 0, $sformatf("R3 vec %0d load commands", i), mis_load, 0);
      check(mis_cmp == 0, $sformatf("R5 vec %0d compare commands", i), mis_cmp, 0);
      check(nstat == 2 * nlog, $sformatf("R4 vec %0d status polls", i), nstat, 2 * nlog);
      check(got_err == exp_err, $sformatf("R6 vec %0d error flag", i), got_err, exp_err);
      check(rx_idx == exp_bytes, $sformatf("R7 vec %0d payload bytes", i), rx_idx, exp_bytes);
      check(data_err == 0 && stray == 0, $sformatf("R7 vec %0d data order and gating", i),
            data_err + stray, 0);
      check(!done_after && !busy_after, $sformatf("R8 vec %0d done pulse", i),
            {done_after, busy_after}, 0);
    end

    // R9: zero length
    run_op(64, 0, 256, 8, 1'b1, 15, 1'b0);
    check(got_done && !got_err, "R9 zero length completes", got_err, 0);
    check(nlog == 0 && nstat == 0, "R9 zero length no commands", nlog + nstat, 0);
    // R9: zero page size
    run_op(64, 10, 0, 8, 1'b0, 15, 1'b0);
    check(got_done && got_err, "R9 zero page size errors", got_err, 1);
    check(nlog == 0 && nstat == 0 && rx_idx == 0, "R9 zero page size no commands",
          nlog + nstat + rx_idx, 0);

    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule